// File: doc/BRIEF.md
# Three-Stage ALU and Parity Pipeline

This block is a short datapath pipeline. On every clock it can take one instruction made of an 8-bit function code and two 4-bit operands. The fetch stage turns the function code into a 3-bit opcode and registers it together with the operands. The execute stage runs a combinational 4-bit ALU on that registered instruction and registers the result. The last stage drives an even-parity bit from the stored result.

A valid flag travels with every instruction through both registers, so the output valid marks the cycles in which the result and its parity belong to an accepted instruction. Results appear two clocks after the instruction is presented, and a new instruction can enter every cycle.

Top module: `alu_parity_pipe`

## Requirements
- R1: The function code is decoded as one-hot, so bit i selects opcode i. When several bits are set, the highest set bit selects the opcode.
- R2: An instruction whose function code is all zeros is dropped, and outValid stays low in the cycle its result would have appeared.
- R3: Opcode 0 (code bit 0) gives A plus B and opcode 1 (code bit 1) gives A minus B, both taken modulo 16 with the carry or borrow discarded.
- R4: Opcodes 2 to 7 (code bits 2 to 7) give A XOR B, A OR B, A AND B, NOR, NAND and XNOR of A and B, in that order.
- R5: When outValid is high, parity is set so that result and parity together hold an even number of ones.
- R6: An instruction presented with inValid high before clock edge n shows its result, parity and outValid high after edge n+1. Instructions presented on consecutive cycles come out on consecutive cycles.
- R7: A synchronous active-high reset clears both pipeline registers, so after reset outValid, result and parity are all zero, and nothing that was in flight comes out.
- R8: A cycle with inValid low produces no output, and outValid is low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies the instruction on the inputs |
| funcCode | input | 8 | One-hot function code |
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand (subtrahend) |
| outValid | output | 1 | Result and parity belong to an accepted instruction |
| result | output | 4 | Registered ALU result |
| parity | output | 1 | Even-parity bit of result |

## Verification
The bench drives the eight opcodes back to back on several operand pairs. Any slip in opcode order, or a stage skipped or doubled, would put results in the wrong slot of the scoreboard. Operand pairs such as 15+1 and 3-12 check that add and subtract wrap without a carry. A design that kept the carry, or computed B minus A, gives a different nibble. Function codes with several bits set catch an encoder that lets the lowest bit win. Zero codes, idle cycles and a reset while instructions are in flight check that the valid bit stays low and that stale data never comes out as valid.

// File: rtl/alu_parity_pkg.sv
package alu_parity_pkg;
  localparam int FUNC_W = 8;
  localparam int OP_W   = $clog2(FUNC_W);

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_XOR  = 3'd2,
    OP_OR   = 3'd3,
    OP_AND  = 3'd4,
    OP_NOR  = 3'd5,
    OP_NAND = 3'd6,
    OP_XNOR = 3'd7
  } aluOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFetch;
    logic loadExec;
  } pipeStrobe_t;
endpackage

// File: rtl/alu_parity_ctrl.sv
module alu_parity_ctrl
  import alu_parity_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [FUNC_W-1:0] funcCode,
  output aluOp_t            opcode,
  output pipeStrobe_t       strobe,
  output logic              outValid
);
  logic            codeHit;
  logic [OP_W-1:0] opIdx;
  logic            fetchValidQ;
  logic            execValidQ;

  // Ascending scan: the highest set bit is written last and wins
  always_comb begin
    codeHit = 1'b0;
    opIdx   = '0;
    for (int i = 0; i < FUNC_W; i++) begin
      if (funcCode[i]) begin
        opIdx   = OP_W'(i);
        codeHit = 1'b1;
      end
    end
  end

  assign opcode           = aluOp_t'(opIdx);
  assign strobe.loadFetch = inValid & codeHit;
  assign strobe.loadExec  = fetchValidQ;
  assign outValid         = execValidQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchValidQ <= 1'b0;
      execValidQ  <= 1'b0;
    end else begin
      fetchValidQ <= strobe.loadFetch;
      execValidQ  <= fetchValidQ;
    end
  end
endmodule

// File: rtl/alu_parity_dp.sv
module alu_parity_dp
  import alu_parity_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pipeStrobe_t       strobe,
  input  aluOp_t            opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              parity
);
  aluOp_t            opQ;
  logic [DATA_W-1:0] aQ;
  logic [DATA_W-1:0] bQ;
  logic [DATA_W-1:0] aluX;
  logic [DATA_W-1:0] xQ;

  // Fetch register
  always_ff @(posedge clk) begin
    if (rst) begin
      opQ <= OP_ADD;
      aQ  <= '0;
      bQ  <= '0;
    end else if (strobe.loadFetch) begin
      opQ <= opcode;
      aQ  <= opA;
      bQ  <= opB;
    end
  end

  // Execute: wrap-around arithmetic, carry discarded
  always_comb begin
    unique case (opQ)
      OP_ADD:  aluX = aQ + bQ;
      OP_SUB:  aluX = aQ - bQ;
      OP_XOR:  aluX = aQ ^ bQ;
      OP_OR:   aluX = aQ | bQ;
      OP_AND:  aluX = aQ & bQ;
      OP_NOR:  aluX = ~(aQ | bQ);
      OP_NAND: aluX = ~(aQ & bQ);
      OP_XNOR: aluX = ~(aQ ^ bQ);
      default: aluX = '0;
    endcase
  end

  // Execute register
  always_ff @(posedge clk) begin
    if (rst) begin
      xQ <= '0;
    end else if (strobe.loadExec) begin
      xQ <= aluX;
    end
  end

  assign result = xQ;
  assign parity = ^xQ;
endmodule

// File: rtl/alu_parity_pipe.sv
module alu_parity_pipe
  import alu_parity_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [FUNC_W-1:0] funcCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              parity
);
  pipeStrobe_t strobe;
  aluOp_t      opcode;

  alu_parity_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .funcCode (funcCode),
    .opcode   (opcode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  alu_parity_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opcode (opcode),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .parity (parity)
  );
endmodule

// File: rtl/alu_parity_pipe_chk.sv
module alu_parity_pipe_chk
  import alu_parity_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [FUNC_W-1:0] funcCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              parity
);
  p_parity_even_r5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (^{result, parity}) == 1'b0);

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && result == '0 && !parity));

  p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(inValid, 2) && $past(funcCode, 2) != '0));

  p_zero_code_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && funcCode == '0) |=> ##1 !outValid);

  p_idle_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  p_add_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(funcCode, 2) == FUNC_W'(1)) |->
      result == DATA_W'($past(opA, 2) + $past(opB, 2)));
endmodule

bind alu_parity_pipe alu_parity_pipe_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_alu_parity_pipe.sv
module tb_alu_parity_pipe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] funcCode = '0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic       outValid;
  logic [3:0] result;
  logic       parity;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    bit       v;
    bit [3:0] x;
    bit       p;
    string    req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  alu_parity_pipe dut (.*);

  function automatic bit [3:0] refAlu(int op, bit [3:0] a, bit [3:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a ^ b;
      3: return a | b;
      4: return a & b;
      5: return ~(a | b);
      6: return ~(a & b);
      default: return ~(a ^ b);
    endcase
  endfunction

  // Driver: present one instruction per cycle and queue its expected output
  task automatic drive(bit v, bit [7:0] f, bit [3:0] a, bit [3:0] b, string req);
    exp_t e;
    int op = 0;
    @(negedge clk);
    #1;
    inValid = v; funcCode = f; opA = a; opB = b;
    for (int i = 0; i < 8; i++) if (f[i]) op = i;  // R1 highest bit wins
    e.v = v && (f != 0);
    e.x = refAlu(op, a, b);
    e.p = ^e.x;
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compare the oldest pending item two cycles after it entered
  always @(negedge clk) begin
    if (!rst && q.size() >= 2) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (outValid !== e.v) begin
        bad++;
        $display("FAIL %s outValid act=%0b exp=%0b", e.req, outValid, e.v);
      end else if (e.v && (result !== e.x || parity !== e.p)) begin
        bad++;
        $display("FAIL %s result/parity act=%h/%0b exp=%h/%0b",
                 e.req, result, parity, e.x, e.p);
      end
    end
  end

  task automatic checkReset(string tag);
    total++;
    if (outValid !== 1'b0 || result !== 4'h0 || parity !== 1'b0) begin
      bad++;
      $display("FAIL %s reset outputs act=%0b/%h/%0b exp=0/0/0",
               tag, outValid, result, parity);
    end
  endtask

  initial begin
    bit [3:0] pa[4] = '{4'h9, 4'hF, 4'h3, 4'h0};
    bit [3:0] pb[4] = '{4'h5, 4'h1, 4'hC, 4'h0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkReset("R7");
    // R3 R4 R5 R6: all opcodes back to back on each operand pair
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 8; op++)
        drive(1'b1, 8'(1 << op), pa[k], pb[k], op < 2 ? "R3" : "R4");
    // R1: multi-hot codes
    drive(1'b1, 8'b1000_0001, 4'hA, 4'h6, "R1");
    drive(1'b1, 8'b0000_0011, 4'h2, 4'h7, "R1");
    drive(1'b1, 8'b0011_1100, 4'hC, 4'hA, "R1");
    // R2: zero code between valid ones
    drive(1'b1, 8'h00, 4'h5, 4'h5, "R2");
    drive(1'b1, 8'h04, 4'h6, 4'h3, "R2");
    // R8: idle cycle with a live code
    drive(1'b0, 8'h01, 4'h7, 4'h7, "R8");
    drive(1'b1, 8'h02, 4'h0, 4'h1, "R8");
    drive(1'b0, 8'h80, 4'h1, 4'h1, "R8");
    drive(1'b0, 8'h00, 4'h0, 4'h0, "R6");
    drive(1'b0, 8'h00, 4'h0, 4'h0, "R6");
    // R7: reset with instructions in flight
    drive(1'b1, 8'h10, 4'hF, 4'hF, "R7");
    drive(1'b1, 8'h20, 4'h0, 4'h0, "R7");
    @(negedge clk);
    #1;
    rst = 1'b1;
    inValid = 1'b0;
    q.delete();
    @(negedge clk);
    #1;
    rst = 1'b0;
    checkReset("R7");
    @(negedge clk);
    #1;
    checkReset("R7");
    drive(1'b1, 8'h01, 4'h8, 4'h8, "R3");
    drive(1'b0, 8'h00, 4'h0, 4'h0, "R6");
    drive(1'b0, 8'h00, 4'h0, 4'h0, "R6");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule